// File: doc/BRIEF.md
# Memory decoder register bank

This block holds the configuration state for four identical host-memory address decoder slots plus two global registers. Software reaches it through one write port (byte address, 32-bit data, write enable) and reads it through a combinational read port. Each slot stores a base, a size, a control word and a pair of target-list words at a fixed stride. The target-list pair can also serve as a skip value.

The control word of each slot carries a commit request bit. A write to a slot's control register is a handshake. If the request bit in the written data is set, that slot becomes committed. If it is clear, the slot is withdrawn. Either way the slot's error flag is cleared. The committed status and the error flag are status bits that the write data cannot set directly. Hardware reports a failed commit through a per-slot error pulse.

A fixed capability register reports the encoded decoder count. A global control register drives the poison-on-error and decode enable outputs. Word writes to a small scratch region outside the decoder window are plain storage with no side effects.

Top module: `mdec_bank`

## Requirements
- R1: Slot i (i = 0..3) occupies byte addresses 0x10 + 0x20*i onward, with these offsets: base low 0x00, base high 0x04, size low 0x08, size high 0x0C, control 0x10, target/skip low 0x14, target/skip high 0x18. The six non-control words store and read back all 32 bits.
- R2: The capability register at address 0x00 always reads 0x0000_0002. Code 2 in bits [3:0] means four decoders. Writes to it have no effect.
- R3: The global control register at 0x04 stores bit 0 as the poison-on-error enable and bit 1 as the decode enable. These bits drive the outputs `poison_en` and `decode_en`. Its other bits read 0.
- R4: A write to a slot's control register with data bit 9 set makes that slot committed from the next cycle. The same write with bit 9 clear makes it uncommitted. No other slot's status changes.
- R5: A slot's error flag (control bit 11) is set by a one-cycle pulse on `slot_err_set[i]`. Any write to that slot's control register clears it. When both occur in the same cycle, the write wins.
- R6: The committed status (control bit 10) and the error flag cannot be set by write data. They change only through R4 and R5.
- R7: Control bits [9:0] are stored as written. Bits [31:12] read 0.
- R8: Word writes to the scratch region 0xC0..0xCF store and read back unchanged, and affect no slot or global register. Addresses that decode to no register read 0, and writes to them have no effect.
- R9: Reset clears every slot and the global control register, so all slots start uncommitted with no error.
- R10: Output `committed[i]` equals slot i's control bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the combinational read |
| rd_data | output | 32 | Read data |
| slot_err_set | input | 4 | Per-slot pulse that raises the error flag |
| committed | output | 4 | Per-slot committed status |
| poison_en | output | 1 | Global poison-on-error enable |
| decode_en | output | 1 | Global decode enable |

## Verification
The assertions assume that the write port presents at most one word per cycle. They also assume that `slot_err_set` is a clean, synchronous pulse that is known whenever reset is released. The bench drives every input on the falling edge, so a write and an error pulse that are aimed at the same cycle really do coincide. The bench reads status only after the rising edge that follows the stimulus. The bench uses only aligned addresses on the register map, the unused holes in it and the scratch words.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  localparam int DW       = 32;
  localparam int CTL_REQ  = 9;   // commit request, stored
  localparam int CTL_DONE = 10;  // committed status, read-only
  localparam int CTL_ERR  = 11;  // error flag, read-only
  localparam int CTL_RW_W = 10;  // writable control bits [9:0]

  typedef enum logic [2:0] {
    F_BASE_LO = 3'd0,
    F_BASE_HI = 3'd1,
    F_SIZE_LO = 3'd2,
    F_SIZE_HI = 3'd3,
    F_CTRL    = 3'd4,
    F_TGT_LO  = 3'd5,
    F_TGT_HI  = 3'd6,
    F_NONE    = 3'd7
  } slot_field_e;

  // Byte offset inside a slot to register field.
  function automatic slot_field_e field_of(input logic [7:0] off);
    case (off)
      8'h00:   return F_BASE_LO;
      8'h04:   return F_BASE_HI;
      8'h08:   return F_SIZE_LO;
      8'h0C:   return F_SIZE_HI;
      8'h10:   return F_CTRL;
      8'h14:   return F_TGT_LO;
      8'h18:   return F_TGT_HI;
      default: return F_NONE;
    endcase
  endfunction

  // Encoded decoder count: 1 -> 0, otherwise n/2.
  function automatic logic [3:0] count_code(input int n);
    return (n <= 1) ? 4'd0 : 4'(n / 2);
  endfunction
endpackage

// File: rtl/mdec_slot.sv
module mdec_slot
  import mdec_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  slot_field_e   wr_field,
  input  logic [DW-1:0] wr_data,
  input  logic          err_set,
  input  slot_field_e   rd_field,
  output logic [DW-1:0] rd_data,
  output logic          committed,
  output logic          err_flag,
  output logic          commit_evt,
  output logic          uncommit_evt
);
  logic [DW-1:0]       store [7];
  logic [CTL_RW_W-1:0] ctrl_rw;
  logic                ctrl_wr;

  assign ctrl_wr      = wr_en && (wr_field == F_CTRL);
  assign commit_evt   = ctrl_wr && wr_data[CTL_REQ];
  assign uncommit_evt = ctrl_wr && !wr_data[CTL_REQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 7; k++) store[k] <= '0;
      ctrl_rw   <= '0;
      committed <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      if (wr_en && wr_field != F_CTRL && wr_field != F_NONE)
        store[int'(wr_field)] <= wr_data;
      if (ctrl_wr) begin
        ctrl_rw   <= wr_data[CTL_RW_W-1:0];
        committed <= commit_evt;
        err_flag  <= 1'b0;
      end else if (err_set) begin
        err_flag  <= 1'b1;
      end
    end
  end

  always_comb begin
    case (rd_field)
      F_CTRL:  rd_data = {{(DW-CTL_ERR-1){1'b0}}, err_flag, committed, ctrl_rw};
      F_NONE:  rd_data = '0;
      default: rd_data = store[int'(rd_field)];
    endcase
  end
endmodule

// File: rtl/mdec_glob.sv
module mdec_glob (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_bits,
  output logic       poison_en,
  output logic       decode_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poison_en <= 1'b0;
      decode_en <= 1'b0;
    end else if (wr_en) begin
      poison_en <= wr_bits[0];
      decode_en <= wr_bits[1];
    end
  end
endmodule

// File: rtl/mdec_scratch.sv
module mdec_scratch #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < WORDS; k++) mem[k] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/mdec_bank.sv
module mdec_bank
  import mdec_pkg::*;
#(
  parameter int NUM_SLOTS     = 4,
  parameter int ADDR_W        = 8,
  parameter int SLOT_BASE     = 'h10,
  parameter int SLOT_STRIDE   = 'h20,
  parameter int SCRATCH_BASE  = 'hC0,
  parameter int SCRATCH_WORDS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [31:0]          rd_data,
  input  logic [NUM_SLOTS-1:0] slot_err_set,
  output logic [NUM_SLOTS-1:0] committed,
  output logic                 poison_en,
  output logic                 decode_en
);
  localparam int SIW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int CIW = (SCRATCH_WORDS > 1) ? $clog2(SCRATCH_WORDS) : 1;
  localparam logic [ADDR_W-1:0] A_CAP   = '0;
  localparam logic [ADDR_W-1:0] A_GCTL  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SLOT0 = ADDR_W'(SLOT_BASE);
  localparam logic [ADDR_W-1:0] A_STRD  = ADDR_W'(SLOT_STRIDE);
  localparam logic [ADDR_W-1:0] A_WEND  = ADDR_W'(SLOT_BASE + (NUM_SLOTS-1)*SLOT_STRIDE + 'h18);
  localparam logic [ADDR_W-1:0] A_SCR   = ADDR_W'(SCRATCH_BASE);
  localparam logic [ADDR_W-1:0] A_SEND  = ADDR_W'(SCRATCH_BASE + 4*SCRATCH_WORDS - 4);
  localparam logic [31:0]       CAP_VAL = {28'd0, count_code(NUM_SLOTS)};

  function automatic logic in_slots(input logic [ADDR_W-1:0] a);
    return (a >= A_SLOT0) && (a <= A_WEND);
  endfunction
  function automatic logic [SIW-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return SIW'((a - A_SLOT0) / A_STRD);
  endfunction
  function automatic slot_field_e fld_of(input logic [ADDR_W-1:0] a);
    return field_of(8'((a - A_SLOT0) % A_STRD));
  endfunction
  function automatic logic in_scr(input logic [ADDR_W-1:0] a);
    return (a >= A_SCR) && (a <= A_SEND) && (a[1:0] == 2'b00);
  endfunction
  function automatic logic [CIW-1:0] scr_of(input logic [ADDR_W-1:0] a);
    return CIW'((a - A_SCR) >> 2);
  endfunction

  // Named internal events for the checker.
  logic [NUM_SLOTS-1:0] commit_evt, uncommit_evt, slot_err;
  logic [31:0]          slot_rd [NUM_SLOTS];
  logic [31:0]          scr_rd;
  logic                 wr_slot_hit, rd_slot_hit;
  logic [SIW-1:0]       wr_slot, rd_slot;
  slot_field_e          wr_fld, rd_fld;

  assign wr_slot_hit = wr_en && in_slots(wr_addr);
  assign wr_slot     = slot_of(wr_addr);
  assign wr_fld      = fld_of(wr_addr);
  assign rd_slot_hit = in_slots(rd_addr);
  assign rd_slot     = slot_of(rd_addr);
  assign rd_fld      = fld_of(rd_addr);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    mdec_slot u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_slot_hit && (wr_slot == SIW'(i))),
      .wr_field     (wr_fld),
      .wr_data      (wr_data),
      .err_set      (slot_err_set[i]),
      .rd_field     (rd_fld),
      .rd_data      (slot_rd[i]),
      .committed    (committed[i]),
      .err_flag     (slot_err[i]),
      .commit_evt   (commit_evt[i]),
      .uncommit_evt (uncommit_evt[i])
    );
  end

  mdec_glob u_glob (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en && (wr_addr == A_GCTL)),
    .wr_bits   (wr_data[1:0]),
    .poison_en (poison_en),
    .decode_en (decode_en)
  );

  mdec_scratch #(.WORDS(SCRATCH_WORDS), .DW(32)) u_scr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en && in_scr(wr_addr)),
    .wr_idx  (scr_of(wr_addr)),
    .wr_data (wr_data),
    .rd_idx  (scr_of(rd_addr)),
    .rd_data (scr_rd)
  );

  always_comb begin
    if (rd_addr == A_CAP)           rd_data = CAP_VAL;
    else if (rd_addr == A_GCTL)     rd_data = {30'd0, decode_en, poison_en};
    else if (rd_slot_hit)           rd_data = slot_rd[rd_slot];
    else if (in_scr(rd_addr))       rd_data = scr_rd;
    else                            rd_data = '0;
  end
endmodule

// File: rtl/mdec_bank_chk.sv
module mdec_bank_chk #(
  parameter int NUM_SLOTS   = 4,
  parameter int ADDR_W      = 8,
  parameter int SLOT_BASE   = 'h10,
  parameter int SLOT_STRIDE = 'h20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [31:0]          wr_data,
  input logic [ADDR_W-1:0]    rd_addr,
  input logic [31:0]          rd_data,
  input logic [NUM_SLOTS-1:0] slot_err_set,
  input logic [NUM_SLOTS-1:0] committed,
  input logic [NUM_SLOTS-1:0] commit_evt,
  input logic [NUM_SLOTS-1:0] uncommit_evt,
  input logic [NUM_SLOTS-1:0] slot_err
);
  // R2: capability word is fixed
  a_r2_cap_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == '0) |-> (rd_data == 32'h2));

  // R4: a single write raises at most one handshake event
  a_r4_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit_evt | uncommit_evt));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(SLOT_BASE + i*SLOT_STRIDE + 'h10);

    a_r4_commit_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == CA && wr_data[9]) |=> committed[i]);

    a_r4_uncommit_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == CA && !wr_data[9]) |=> !committed[i]);

    a_r6_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == CA) |=> $stable(committed[i]));

    a_r5_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == CA) |=> !slot_err[i]);

    a_r5_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_err_set[i] && !(wr_en && wr_addr == CA)) |=> slot_err[i]);
  end
endmodule

bind mdec_bank mdec_bank_chk #(
  .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W),
  .SLOT_BASE(SLOT_BASE), .SLOT_STRIDE(SLOT_STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
  .slot_err_set(slot_err_set), .committed(committed),
  .commit_evt(commit_evt), .uncommit_evt(uncommit_evt), .slot_err(slot_err)
);

// File: tb/mdec_bank_test.sv
module mdec_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  slot_err_set = '0;
  logic [3:0]  committed;
  logic        poison_en, decode_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mdec_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .slot_err_set(slot_err_set), .committed(committed),
    .poison_en(poison_en), .decode_en(decode_en)
  );

  function automatic logic [7:0] reg_at(input int slot, input int off);
    return 8'('h10 + 'h20*slot + off);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] es = '0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; slot_err_set = es;
    @(negedge clk);
    wr_en = 1'b0; slot_err_set = '0;
  endtask

  task automatic pulse_err(input logic [3:0] es);
    @(negedge clk);
    slot_err_set = es;
    @(negedge clk);
    slot_err_set = '0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset();
    rd_check("R2", 8'h00, 32'h2);
    rd_check("R9", 8'h04, 32'h0);
    for (int s = 0; s < 4; s++) rd_check("R9", reg_at(s, 'h10), 32'h0);
    check("R9", {28'd0, committed}, 32'h0);
    check("R9", {30'd0, decode_en, poison_en}, 32'h0);
  endtask

  task automatic t_layout();
    int offs[6] = '{'h00, 'h04, 'h08, 'h0C, 'h14, 'h18};
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 6; f++)
        wr(reg_at(s, offs[f]), {8'(s), 8'(f), 16'hA5C3});
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 6; f++)
        rd_check("R1", reg_at(s, offs[f]), {8'(s), 8'(f), 16'hA5C3});
    rd_check("R1", reg_at(1, 'h10), 32'h0);
  endtask

  task automatic t_global();
    wr(8'h04, 32'hFFFF_FFFF);
    rd_check("R3", 8'h04, 32'h3);
    check("R3", {30'd0, decode_en, poison_en}, 32'h3);
    wr(8'h04, 32'h0000_0002);
    check("R3", {30'd0, decode_en, poison_en}, 32'h2);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_check("R2", 8'h00, 32'h2);
  endtask

  task automatic t_commit();
    wr(reg_at(2, 'h10), 32'h0000_0235);
    check("R4", {28'd0, committed}, 32'h4);
    rd_check("R10", reg_at(2, 'h10), 32'h0000_0635);
    wr(reg_at(1, 'h10), 32'h0000_0200);
    check("R4", {28'd0, committed}, 32'h6);
    wr(reg_at(2, 'h10), 32'h0000_0035);
    check("R4", {28'd0, committed}, 32'h2);
    rd_check("R7", reg_at(2, 'h10), 32'h0000_0035);
  endtask

  task automatic t_readonly();
    wr(reg_at(3, 'h10), 32'hFFFF_FD0F);
    rd_check("R6", reg_at(3, 'h10), 32'h0000_010F);
    check("R6", {28'd0, committed}, 32'h2);
    wr(reg_at(3, 'h10), 32'hFFFF_FFFF);
    rd_check("R7", reg_at(3, 'h10), 32'h0000_07FF);
    check("R10", {28'd0, committed}, 32'hA);
  endtask

  task automatic t_error();
    pulse_err(4'b0001);
    rd_check("R5", reg_at(0, 'h10), 32'h0000_0800);
    wr(reg_at(0, 'h10), 32'h0000_0200);
    rd_check("R5", reg_at(0, 'h10), 32'h0000_0600);
    wr(reg_at(0, 'h10), 32'h0000_0201, 4'b0001);
    rd_check("R5", reg_at(0, 'h10), 32'h0000_0601);
    pulse_err(4'b0001);
    wr(reg_at(0, 'h10), 32'h0000_0000);
    rd_check("R5", reg_at(0, 'h10), 32'h0000_0000);
    check("R5", {28'd0, committed}, 32'hA);
  endtask

  task automatic t_outside();
    wr(8'hC4, 32'hDEAD_BEEF);
    wr(8'hCC, 32'h1234_5678);
    rd_check("R8", 8'hC4, 32'hDEAD_BEEF);
    rd_check("R8", 8'hCC, 32'h1234_5678);
    rd_check("R8", reg_at(0, 'h00), {8'd0, 8'd0, 16'hA5C3});
    check("R8", {28'd0, committed}, 32'hA);
    wr(8'h08, 32'hFFFF_FFFF);
    rd_check("R8", 8'h08, 32'h0);
    wr(reg_at(0, 'h1C), 32'hFFFF_FFFF);
    rd_check("R8", reg_at(0, 'h1C), 32'h0);
    rd_check("R8", 8'h04, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_global();
    t_commit();
    t_readonly();
    t_error();
    t_outside();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule